// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the software-visible register file for one DMA channel. Software drives it through a simple 32-bit read/write port with a byte address. It holds four registers. The control register carries the run bit, a sticky soft-reset bit, interrupt enables, a completion threshold and a delay timeout. The status register carries the halted and idle flags and three pending interrupt flags. Two further registers hold the current and tail descriptor pointers.

The data mover sits beside the block and is not part of it. The block gives the mover its run level, its soft-reset level, the threshold and timeout fields and both pointers. It also gives two strobes: one when software writes the tail pointer and one when a run-start write reloads the completion counter. In return the mover sends one-cycle pulses to set halted, idle and each interrupt flag. It also sends its live completion count and delay-timer value, and these show up when software reads the control register.

A single level interrupt leaves the block. It is high whenever a pending flag is set and its enable is set too.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the status register reads 0x0000_0001 (halted only), the stored threshold field (`mv_cmpl_thresh`) equals `RST_THRESH` (default 1), and every other control, delay and pointer bit is 0.
- R2: A control write (byte offset 0x00) stores the written word, except that bit 1 (tail mode) always reads 1 afterwards. Bits 23:16 drive `mv_cmpl_thresh`, bits 31:24 drive `mv_delay_tmo` and bit 0 drives `mv_run`.
- R3: Control bit 2 (soft reset) stays set through later control writes that leave it 0. A control read returns it still set and then clears it. `mv_soft_reset` follows the stored bit.
- R4: A control write with bit 0 set clears status bits 0 (halted) and 1 (idle) and pulses `mv_count_reload` for one cycle, but only if bit 2 is 0 both in the written word and in storage. Otherwise both status bits and the strobe are unchanged.
- R5: Status bits 12 (completion), 13 (delay) and 14 (error) are set by `mv_done_set`, `mv_delay_set` and `mv_err_set`. A status write (offset 0x04) clears each of those bits written as 1. A set pulse in the same cycle as a clear wins.
- R6: Status bits 0 and 1 are set only by `mv_halt_set` and `mv_idle_set`. Software writes to status bits 1:0 have no effect.
- R7: `irq` is high exactly when some bit in status 14:12 is set and the control bit at the same position is also set.
- R8: A write to the tail pointer (offset 0x10) stores the value, clears status idle and raises `mv_tail_strobe` for the one cycle after the write.
- R9: The current pointer (offset 0x08) is written and read back as stored, and it drives `mv_cur_desc`.
- R10: A control read returns stored bits 15:0, `mv_live_count` in bits 23:16 and `mv_live_timer` in bits 31:24.
- R11: Reads of any other offset, and of any address that is not word-aligned, return 0.
- R12: Read data appears on `reg_rdata` in the cycle after `reg_rd_en` and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| mv_run | output | 1 | Run level to the data mover |
| mv_soft_reset | output | 1 | Stored soft-reset bit |
| mv_tail_strobe | output | 1 | One-cycle pulse after a tail-pointer write |
| mv_count_reload | output | 1 | One-cycle pulse after a run-start write |
| mv_cmpl_thresh | output | 8 | Stored completion threshold |
| mv_delay_tmo | output | 8 | Stored delay timeout |
| mv_cur_desc | output | DESC_W | Current descriptor pointer |
| mv_tail_desc | output | DESC_W | Tail descriptor pointer |
| mv_halt_set | input | 1 | Pulse: set halted |
| mv_idle_set | input | 1 | Pulse: set idle |
| mv_done_set | input | 1 | Pulse: set completion interrupt |
| mv_delay_set | input | 1 | Pulse: set delay interrupt |
| mv_err_set | input | 1 | Pulse: set error interrupt |
| mv_live_count | input | 8 | Live completion count for read-back |
| mv_live_timer | input | 8 | Live delay-timer value for read-back |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with ADDR_W = 6, DESC_W = 32 and RST_THRESH = 1. The 6-bit address reaches every offset up to 0x3C, so the unmapped words at 0x0C, 0x14, 0x20 and 0x3C can be read, and so can an address that is not word-aligned. With the full 32-bit pointer width, the top bits of a pointer travel through to read-back and to the mover outputs. The default threshold of 1 makes the reset value of the threshold field distinct from zero.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;
  localparam int WORD_W   = 32;
  localparam int FIELD_W  = 8;

  // Byte offsets of the mapped words.
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_CUR  = 'h08;
  localparam int OFS_TAIL = 'h10;

  // Control bit positions.
  localparam int CB_RUN   = 0;
  localparam int CB_TAIL  = 1;
  localparam int CB_SRST  = 2;
  localparam int CB_THR   = 16;
  localparam int CB_DLY   = 24;

  // Status bit positions.
  localparam int SB_HALT  = 0;
  localparam int SB_IDLE  = 1;

  // Interrupt group, shared by status flags and control enables.
  localparam int IRQ_LO   = 12;
  localparam int IRQ_N    = 3;
  localparam int IRQ_HI   = IRQ_LO + IRQ_N - 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_STAT,
    SEL_CUR,
    SEL_TAIL
  } reg_sel_e;
endpackage

// File: rtl/dmachan_decode.sv
module dmachan_decode
  import dmachan_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             aligned;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel = SEL_NONE;
    if (aligned) begin
      if (widx == IDX_W'(OFS_CTRL >> 2))      sel = SEL_CTRL;
      else if (widx == IDX_W'(OFS_STAT >> 2)) sel = SEL_STAT;
      else if (widx == IDX_W'(OFS_CUR >> 2))  sel = SEL_CUR;
      else if (widx == IDX_W'(OFS_TAIL >> 2)) sel = SEL_TAIL;
    end
  end
endmodule

// File: rtl/dmachan_ctrl.sv
module dmachan_ctrl
  import dmachan_pkg::*;
#(
  parameter int RST_THRESH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              run_start,
  output logic              reload_q
);
  localparam logic [WORD_W-1:0] RST_VAL =
    WORD_W'(RST_THRESH % (1 << FIELD_W)) << CB_THR;

  logic [WORD_W-1:0] ctrl_d;
  logic              ctrl_en;

  // Next state: writes force tail mode and keep a pending soft reset;
  // a read clears the soft-reset bit after it has been returned.
  always_comb begin
    ctrl_d  = ctrl_q;
    ctrl_en = wr | rd;
    if (wr) begin
      ctrl_d          = wdata;
      ctrl_d[CB_TAIL] = 1'b1;
      ctrl_d[CB_SRST] = wdata[CB_SRST] | ctrl_q[CB_SRST];
    end else if (rd) begin
      ctrl_d[CB_SRST] = 1'b0;
    end
  end

  assign run_start = wr & wdata[CB_RUN] & ~(wdata[CB_SRST] | ctrl_q[CB_SRST]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= RST_VAL;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= 1'b0;
    end else begin
      reload_q <= run_start;
    end
  end

  // R2
  tail_mode_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ctrl_q[CB_TAIL]);

  // R3
  srst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_SRST] && !rd) |=> ctrl_q[CB_SRST]);

  // R3
  srst_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !ctrl_q[CB_SRST]);

  // R4
  reload_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reload_q) |-> $past(wr && wdata[CB_RUN]));
endmodule

// File: rtl/dmachan_stat.sv
module dmachan_stat
  import dmachan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IRQ_N-1:0]  clr_mask,
  input  logic              run_start,
  input  logic              tail_wr,
  input  logic              halt_set,
  input  logic              idle_set,
  input  logic [IRQ_N-1:0]  irq_set,
  output logic [WORD_W-1:0] stat_q
);
  logic             halt_q, halt_d;
  logic             idle_q, idle_d;
  logic [IRQ_N-1:0] pend_q, pend_d;
  logic             upd;

  // Flags are cleared by their events, then set pulses override.
  always_comb begin
    halt_d = halt_set | (halt_q & ~run_start);
    idle_d = idle_set | (idle_q & ~(run_start | tail_wr));
    upd    = wr | run_start | tail_wr | halt_set | idle_set | (|irq_set);
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_pend
    always_comb begin
      pend_d[i] = irq_set[i] | (pend_q[i] & ~(wr & clr_mask[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      idle_q <= 1'b0;
      pend_q <= '0;
    end else if (upd) begin
      halt_q <= halt_d;
      idle_q <= idle_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    stat_q                = '0;
    stat_q[SB_HALT]       = halt_q;
    stat_q[SB_IDLE]       = idle_q;
    stat_q[IRQ_HI:IRQ_LO] = pend_q;
  end

  // R6
  halt_only_by_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_q) |-> $past(halt_set));

  // R6
  idle_only_by_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_q) |-> $past(idle_set));

  // R4
  run_clears_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_start && !halt_set) |=> !halt_q);

  // R5
  w1c_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && clr_mask[0] && !irq_set[0]) |=> !pend_q[0]);

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set[2] |=> pend_q[2]);
endmodule

// File: rtl/dmachan_ptr.sv
module dmachan_ptr #(
  parameter int DESC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DESC_W-1:0] wdata,
  output logic [DESC_W-1:0] ptr_q
);
  logic [DESC_W-1:0] ptr_d;

  always_comb begin
    ptr_d = wr ? wdata : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (wr) begin
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmachan_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DESC_W     = 32,
  parameter int RST_THRESH = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               mv_run,
  output logic               mv_soft_reset,
  output logic               mv_tail_strobe,
  output logic               mv_count_reload,
  output logic [7:0]         mv_cmpl_thresh,
  output logic [7:0]         mv_delay_tmo,
  output logic [DESC_W-1:0]  mv_cur_desc,
  output logic [DESC_W-1:0]  mv_tail_desc,
  input  logic               mv_halt_set,
  input  logic               mv_idle_set,
  input  logic               mv_done_set,
  input  logic               mv_delay_set,
  input  logic               mv_err_set,
  input  logic [7:0]         mv_live_count,
  input  logic [7:0]         mv_live_timer,
  output logic               irq
);
  reg_sel_e          sel;
  logic              wr_ctrl, wr_stat, wr_cur, wr_tail, rd_ctrl;
  logic [WORD_W-1:0] ctrl_q, stat_q;
  logic              run_start;
  logic [WORD_W-1:0] rdata_d, rdata_q;
  logic              tail_pls_d, tail_pls_q;

  dmachan_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  assign wr_ctrl = reg_wr_en & (sel == SEL_CTRL);
  assign wr_stat = reg_wr_en & (sel == SEL_STAT);
  assign wr_cur  = reg_wr_en & (sel == SEL_CUR);
  assign wr_tail = reg_wr_en & (sel == SEL_TAIL);
  assign rd_ctrl = reg_rd_en & (sel == SEL_CTRL);

  dmachan_ctrl #(.RST_THRESH(RST_THRESH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_ctrl),
    .rd        (rd_ctrl),
    .wdata     (reg_wdata),
    .ctrl_q    (ctrl_q),
    .run_start (run_start),
    .reload_q  (mv_count_reload)
  );

  dmachan_stat u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_stat),
    .clr_mask  (reg_wdata[IRQ_HI:IRQ_LO]),
    .run_start (run_start),
    .tail_wr   (wr_tail),
    .halt_set  (mv_halt_set),
    .idle_set  (mv_idle_set),
    .irq_set   ({mv_err_set, mv_delay_set, mv_done_set}),
    .stat_q    (stat_q)
  );

  dmachan_ptr #(.DESC_W(DESC_W)) u_cur (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_cur),
    .wdata (reg_wdata[DESC_W-1:0]),
    .ptr_q (mv_cur_desc)
  );

  dmachan_ptr #(.DESC_W(DESC_W)) u_tail (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_tail),
    .wdata (reg_wdata[DESC_W-1:0]),
    .ptr_q (mv_tail_desc)
  );

  // Tail strobe to the mover, one cycle after the write.
  assign tail_pls_d = wr_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_pls_q <= 1'b0;
    end else begin
      tail_pls_q <= tail_pls_d;
    end
  end

  // Read mux; the control word carries the live counter values on top.
  always_comb begin
    unique case (sel)
      SEL_CTRL: rdata_d = {mv_live_timer, mv_live_count, ctrl_q[15:0]};
      SEL_STAT: rdata_d = stat_q;
      SEL_CUR:  rdata_d = WORD_W'(mv_cur_desc);
      SEL_TAIL: rdata_d = WORD_W'(mv_tail_desc);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata       = rdata_q;
  assign mv_tail_strobe  = tail_pls_q;
  assign mv_run          = ctrl_q[CB_RUN];
  assign mv_soft_reset   = ctrl_q[CB_SRST];
  assign mv_cmpl_thresh  = ctrl_q[CB_THR +: FIELD_W];
  assign mv_delay_tmo    = ctrl_q[CB_DLY +: FIELD_W];
  assign irq             = |(stat_q[IRQ_HI:IRQ_LO] & ctrl_q[IRQ_HI:IRQ_LO]);

  // R8
  tail_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tail |=> mv_tail_strobe);

  // R8
  tail_strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_tail_strobe && !wr_tail) |=> !mv_tail_strobe);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && sel == SEL_NONE) |=> (reg_rdata == '0));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata));
endmodule

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic          reg_rd_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          mv_run, mv_soft_reset, mv_tail_strobe, mv_count_reload;
  logic [7:0]    mv_cmpl_thresh, mv_delay_tmo;
  logic [DW-1:0] mv_cur_desc, mv_tail_desc;
  logic [4:0]    ev = '0; // {err, delay, done, idle, halt}
  logic [7:0]    live_cnt = '0;
  logic [7:0]    live_tmr = '0;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs #(.ADDR_W(AW), .DESC_W(DW), .RST_THRESH(1)) u0 (
    .clk (clk), .rst_n (rst_n),
    .reg_wr_en (reg_wr_en), .reg_rd_en (reg_rd_en),
    .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .mv_run (mv_run), .mv_soft_reset (mv_soft_reset),
    .mv_tail_strobe (mv_tail_strobe), .mv_count_reload (mv_count_reload),
    .mv_cmpl_thresh (mv_cmpl_thresh), .mv_delay_tmo (mv_delay_tmo),
    .mv_cur_desc (mv_cur_desc), .mv_tail_desc (mv_tail_desc),
    .mv_halt_set (ev[0]), .mv_idle_set (ev[1]), .mv_done_set (ev[2]),
    .mv_delay_set (ev[3]), .mv_err_set (ev[4]),
    .mv_live_count (live_cnt), .mv_live_timer (live_tmr),
    .irq (irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // Driver: issue a read and push the expected word to the scoreboard.
  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  always @(posedge clk) rd_seen <= reg_rd_en;

  // Monitor: compare each read result with the scoreboard head.
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        chk(1, 0, "R12 unexpected read result");
      end else begin
        chk(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd('h04, 32'h0000_0001, "R1 status after reset");
    rd('h00, 32'h0000_0000, "R1 control after reset");
    chk(32'(mv_cmpl_thresh), 32'd1, "R1 threshold reset");
    chk(32'(mv_delay_tmo), 32'd0, "R1 delay reset");
    chk(32'(irq), 32'd0, "R1 irq reset");
    rd('h08, 32'h0, "R1 cur reset");
    rd('h10, 32'h0, "R1 tail reset");

    live_cnt = 8'h5A; live_tmr = 8'hC3;
    // R4 run start, R2 tail mode forced
    wr('h00, 32'h0A0B_7001);
    chk(32'(mv_count_reload), 32'd1, "R4 reload pulse");
    chk(32'(mv_run), 32'd1, "R2 run out");
    chk(32'(mv_cmpl_thresh), 32'h0B, "R2 threshold field");
    chk(32'(mv_delay_tmo), 32'h0A, "R2 delay field");
    @(negedge clk);
    chk(32'(mv_count_reload), 32'd0, "R4 reload one cycle");
    rd('h04, 32'h0, "R4 halted cleared");
    rd('h00, 32'hC35A_7003, "R10 R2 control read live");

    // R5 and R7
    pulse(5'b00100);
    chk(32'(irq), 32'd1, "R7 irq on done");
    rd('h04, 32'h0000_1000, "R5 done pending");
    wr('h04, 32'h0000_1000);
    chk(32'(irq), 32'd0, "R7 irq cleared");
    rd('h04, 32'h0, "R5 w1c done");

    wr('h00, 32'h0A0B_0001);
    pulse(5'b01000);
    chk(32'(irq), 32'd0, "R7 masked delay");
    rd('h04, 32'h0000_2000, "R5 delay pending");
    wr('h00, 32'h0A0B_2001);
    chk(32'(irq), 32'd1, "R7 enabled delay");
    wr('h04, 32'h0000_2003);
    chk(32'(irq), 32'd0, "R7 irq after w1c");
    rd('h04, 32'h0, "R6 R5 write no set");

    // R5 set wins over clear
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 'h04; reg_wdata = 32'h0000_4000; ev = 5'b10000;
    @(negedge clk);
    reg_wr_en = 1'b0; ev = '0;
    rd('h04, 32'h0000_4000, "R5 set wins");
    wr('h04, 32'h0000_4000);
    rd('h04, 32'h0, "R5 w1c err");

    // R6 halted/idle only by pulses
    pulse(5'b00001);
    pulse(5'b00010);
    rd('h04, 32'h0000_0003, "R6 pulses set flags");
    wr('h04, 32'h0);
    rd('h04, 32'h0000_0003, "R6 software write ignored");

    // R8 tail write
    wr('h10, 32'h1234_5670);
    chk(32'(mv_tail_strobe), 32'd1, "R8 tail strobe");
    @(negedge clk);
    chk(32'(mv_tail_strobe), 32'd0, "R8 tail strobe one cycle");
    chk(mv_tail_desc, 32'h1234_5670, "R8 tail out");
    rd('h04, 32'h0000_0001, "R8 idle cleared");
    rd('h10, 32'h1234_5670, "R8 tail read");

    // R9 current pointer
    wr('h08, 32'hDEAD_BEE0);
    chk(mv_cur_desc, 32'hDEAD_BEE0, "R9 cur out");
    rd('h08, 32'hDEAD_BEE0, "R9 cur read");

    // R3 soft reset sticky, blocks run start
    wr('h00, 32'h0001_0005);
    chk(32'(mv_soft_reset), 32'd1, "R3 soft reset out");
    chk(32'(mv_count_reload), 32'd0, "R4 no reload in reset");
    wr('h00, 32'h0001_0001);
    chk(32'(mv_soft_reset), 32'd1, "R3 sticky through write");
    chk(32'(mv_count_reload), 32'd0, "R4 no reload held reset");
    rd('h04, 32'h0000_0001, "R4 halted kept in reset");
    rd('h00, 32'hC35A_0007, "R3 read shows reset");
    chk(32'(mv_soft_reset), 32'd0, "R3 cleared by read");
    rd('h00, 32'hC35A_0003, "R3 second read");
    wr('h00, 32'h0001_0001);
    chk(32'(mv_count_reload), 32'd1, "R4 reload after reset");
    rd('h04, 32'h0, "R4 halted cleared after reset");

    // R11 unmapped
    rd('h0C, 32'h0, "R11 offset 0x0C");
    rd('h14, 32'h0, "R11 offset 0x14");
    rd('h20, 32'h0, "R11 offset 0x20");
    rd('h3C, 32'h0, "R11 offset 0x3C");
    rd('h09, 32'h0, "R11 unaligned");

    // R12 hold
    rd('h00, 32'hC35A_0003, "R12 control read");
    live_cnt = 8'h11;
    repeat (2) @(negedge clk);
    chk(reg_rdata, 32'hC35A_0003, "R12 data held");
    rd('h00, 32'hC311_0003, "R10 new live count");

    repeat (3) @(negedge clk);
    chk(32'(exp_q.size()), 32'd0, "R12 scoreboard drained");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule